// File: doc/BRIEF.md
# Framed PCM Serial Port

This block is a synchronous serial port. Once per frame it moves one fixed-length word on each of two transmit lanes and two receive lanes. Frames repeat every `FRAME_BITS` bit-clock periods, which is 256 for an 8 kHz frame on a 2.048 MHz bit clock. Words go out and come in MSB first. Transmit bits change on the rising bit-clock edge. Receive bits, and the frame syncs, are sampled on the falling edge. All logic runs in the system clock domain, and bit-clock edges are detected as events.

The `ext_mode` input selects one of two clocking modes. In internal mode the port divides the system clock by `DIV` to make the bit clock and drives it, with the output enable high. It also makes an active-high framing pulse, and transmit and receive both run from that pulse. In external mode the bit clock pin is an input, and the output enable stays low. Two active-low syncs drive the transfers: one for transmit and one for receive. The falling edge of a sync starts a transfer. Its rising edge commits it: the receive word is handed to the host, or the next transmit word is latched. The host writes one transmit word per lane with a load strobe and gets the received words with a one-cycle valid pulse.

Top module: `pcm_frame_port`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sclk_oe` is 0 so the bit clock pin floats, both transmit lanes are 1, `rx_valid` is 0 and `frame_out` is 0.
- R2: In internal mode `sclk_oe` is 1 and `sclk_out` has a period of `DIV` system clocks (`DIV` even, at least 4). It starts high and is low for the first `DIV/2` cycles after the first `DIV/2`.
- R3: In internal mode `frame_out` is high for exactly one bit-clock period in every `FRAME_BITS` periods. That period starts at the first rising bit-clock edge after reset.
- R4: In external mode `sclk_oe` and `frame_out` stay 0.
- R5: A transfer starts at the falling bit-clock edge where the sync is first seen active. In internal mode the sync is active while `frame_out` is high. The word's MSB is driven at the next rising edge and each following rising edge drives the next lower bit. After the LSB the lane returns to 1.
- R6: In internal mode the receive lanes are sampled MSB first on the 8 falling edges that follow the frame's start. `rx_valid` pulses for one cycle on the eighth sample. `rx_word` then holds lane 1 in bits [15:8] and lane 0 in bits [7:0].
- R7: In external mode `rx_valid` pulses only when the receive sync is first seen inactive again on a falling edge. `rx_word` then holds the bits sampled while the sync was low.
- R8: The transmit commit latches the host word that goes out in the next transfer. In external mode the commit is the rising edge of the transmit sync, seen on a falling edge. In internal mode it is the falling edge at the end of the framing pulse. A word loaded before a commit is sent in the transfer that follows that commit, and not in the transfer already under way.
- R9: A lane with no word loaded since the previous commit sends all ones in the following transfer.
- R10: A load strobe in the same cycle as a commit is taken by that commit. Of two loads before one commit, the later one is sent.
- R11: In external mode the transmit and receive syncs act independently. A receive-only frame neither shifts nor commits transmit data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_mode | input | 1 | 1 = external clocking, 0 = internal clocking |
| sclk_in | input | 1 | Bit clock from the pin (external mode) |
| sclk_out | output | 1 | Generated bit clock (internal mode) |
| sclk_oe | output | 1 | Pin driver enable for the bit clock |
| fsx_n | input | 1 | Active-low transmit frame sync (external mode) |
| fsr_n | input | 1 | Active-low receive frame sync (external mode) |
| frame_out | output | 1 | Active-high framing pulse (internal mode) |
| rx_lane | input | LANES | Serial receive lanes |
| tx_lane | output | LANES | Serial transmit lanes |
| tx_load | input | LANES | Per-lane transmit word load strobe |
| tx_word | input | LANES*WORD_BITS | Transmit words, lane n at [n*WORD_BITS +: WORD_BITS] |
| rx_word | output | LANES*WORD_BITS | Received words, same packing |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification
A host load strobe can fall in the same system cycle as a transmit commit. The bench provokes this in internal mode by driving `tx_load` on both lanes exactly on the commit edge, after an earlier load on lane 1 in the same frame. A behavioural model running per clock predicts which word each lane sends in the next frame, so the bypass and the overwrite are both judged from the serial bits. In external mode, receive completion and transmit commit share one falling edge when both syncs rise together. Both results are checked after every such frame.

// File: rtl/pcm_frame_port.sv
module pcm_frame_port #(
  parameter int DIV        = 4,
  parameter int FRAME_BITS = 256,
  parameter int WORD_BITS  = 8,
  parameter int LANES      = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ext_mode,
  input  logic                       sclk_in,
  output logic                       sclk_out,
  output logic                       sclk_oe,
  input  logic                       fsx_n,
  input  logic                       fsr_n,
  output logic                       frame_out,
  input  logic [LANES-1:0]           rx_lane,
  output logic [LANES-1:0]           tx_lane,
  input  logic [LANES-1:0]           tx_load,
  input  logic [LANES*WORD_BITS-1:0] tx_word,
  output logic [LANES*WORD_BITS-1:0] rx_word,
  output logic                       rx_valid
);
  localparam int HALF = DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int FW   = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int CW   = $clog2(WORD_BITS + 1);

  logic [DW-1:0]    div_cnt;
  logic             sclk_int;
  logic [FW-1:0]    bit_cnt;
  logic             sclk_s, sclk_d, fsx_s, fsr_s, fsx_last, fsr_last, oe_q;
  logic [LANES-1:0] rx_s;
  logic [CW-1:0]    rx_cnt;

  wire half_done = (div_cnt == DW'(HALF - 1));
  wire rise      = ext_mode ? (sclk_s & ~sclk_d) : (half_done & ~sclk_int);
  wire fall      = ext_mode ? (~sclk_s & sclk_d) : (half_done & sclk_int);
  wire in_frame  = (bit_cnt == '0);
  wire fsx_now   = ext_mode ? fsx_s : ~in_frame;
  wire fsr_now   = ext_mode ? fsr_s : ~in_frame;

  wire tx_start  = fall & ~fsx_now & fsx_last;
  wire tx_commit = fall & fsx_now & ~fsx_last;
  wire rx_start  = fall & ~fsr_now & fsr_last;
  wire rx_end    = ext_mode & fall & fsr_now & ~fsr_last;
  wire rx_busy   = (rx_cnt != CW'(WORD_BITS));
  wire rx_take   = fall & ~rx_start & ~rx_end & rx_busy;
  wire rx_fin    = ext_mode ? rx_end : (rx_take & (rx_cnt == CW'(WORD_BITS - 1)));

  assign sclk_out  = sclk_int;
  assign sclk_oe   = oe_q;
  assign frame_out = ~ext_mode & in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      sclk_int <= 1'b1;
      bit_cnt  <= FW'(FRAME_BITS - 1);
      sclk_s   <= 1'b1;
      sclk_d   <= 1'b1;
      fsx_s    <= 1'b1;
      fsr_s    <= 1'b1;
      fsx_last <= 1'b1;
      fsr_last <= 1'b1;
      rx_s     <= '0;
      oe_q     <= 1'b0;
      rx_cnt   <= CW'(WORD_BITS);
      rx_valid <= 1'b0;
    end else begin
      oe_q   <= ~ext_mode;
      sclk_s <= sclk_in;
      sclk_d <= sclk_s;
      fsx_s  <= fsx_n;
      fsr_s  <= fsr_n;
      rx_s   <= rx_lane;
      if (half_done) begin
        div_cnt  <= '0;
        sclk_int <= ~sclk_int;
        if (!sclk_int)
          bit_cnt <= (bit_cnt == FW'(FRAME_BITS - 1)) ? '0 : bit_cnt + 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
      if (fall) begin
        fsx_last <= fsx_now;
        fsr_last <= fsr_now;
      end
      if (rx_start)                  rx_cnt <= '0;
      else if (rx_end || rx_fin)     rx_cnt <= CW'(WORD_BITS);
      else if (rx_take)              rx_cnt <= rx_cnt + 1'b1;
      rx_valid <= rx_fin;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_BITS-1:0] hold, stage, tx_sh, rx_sh;
    logic                 loaded, tx_q;
    wire  [WORD_BITS-1:0] new_word = tx_word[l*WORD_BITS +: WORD_BITS];
    wire  [WORD_BITS-1:0] eff_word = tx_load[l] ? new_word : hold;
    wire                  eff_ok   = tx_load[l] | loaded;
    wire  [WORD_BITS-1:0] rx_next  = rx_take ? {rx_sh[WORD_BITS-2:0], rx_s[l]} : rx_sh;

    assign tx_lane[l] = tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold    <= '0;
        loaded  <= 1'b0;
        stage   <= '1;
        tx_sh   <= '1;
        tx_q    <= 1'b1;
        rx_sh   <= '0;
        rx_word[l*WORD_BITS +: WORD_BITS] <= '0;
      end else begin
        if (tx_commit) begin
          stage  <= eff_ok ? eff_word : '1;
          loaded <= 1'b0;
        end else if (tx_load[l]) begin
          hold   <= new_word;
          loaded <= 1'b1;
        end
        if (tx_start)   tx_sh <= stage;
        else if (rise)  tx_sh <= {tx_sh[WORD_BITS-2:0], 1'b1};
        if (rise)       tx_q  <= tx_sh[WORD_BITS-1];
        rx_sh <= rx_next;
        if (rx_fin) rx_word[l*WORD_BITS +: WORD_BITS] <= rx_next;
      end
    end
  end
endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode,
  input logic             sclk_out,
  input logic             sclk_oe,
  input logic             frame_out,
  input logic [LANES-1:0] tx_lane,
  input logic             rx_valid
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sclk_oe && tx_lane == '1 && !rx_valid && !frame_out));

  assert_sclk_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && $rose(sclk_out)) |=> sclk_out);

  assert_frame_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_out) |=> frame_out);

  assert_ext_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && $past(ext_mode)) |-> (!sclk_oe && !frame_out));

  assert_tx_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && tx_lane != $past(tx_lane)) |-> $rose(sclk_out));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind pcm_frame_port pcm_frame_port_chk #(.LANES(LANES)) chk_i (.*);

// File: tb/pcm_frame_port_tb_top.sv
module pcm_frame_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4, HALF = DIV / 2, FB = 256, W = 8, L = 2;
  localparam int FRAME_CLK = DIV * FB;
  localparam int R_START   = DIV + HALF;
  localparam int R_COMMIT  = 2 * DIV + HALF;
  localparam int R_TX0     = 2 * DIV;
  localparam int R_RXV     = 9 * DIV + HALF;

  logic clk = 0, rst_n = 0, ext_mode = 0, sclk_in = 1, fsx_n = 1, fsr_n = 1;
  logic sclk_out, sclk_oe, frame_out, rx_valid;
  logic [L-1:0] rx_lane = '0, tx_lane, tx_load = '0;
  logic [L*W-1:0] tx_word = '0, rx_word;

  int errors = 0, checks = 0, k = 0;
  logic int_phase = 0, done = 0;
  logic [W-1:0] m_stage [L], m_hold [L], m_cur [L];
  logic         m_loaded [L];
  int got_cnt = 0;
  logic [L*W-1:0] got_word = '0;

  pcm_frame_port #(.DIV(DIV), .FRAME_BITS(FB), .WORD_BITS(W), .LANES(L)) dut_i (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at k=%0d: actual=%0h expected=%0h", req, k, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int f, input int l);
    return W'(8'hA5 ^ (f * 37) ^ (l * 8'h3C));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0;
      for (int l = 0; l < L; l++) begin
        m_stage[l] = '1; m_hold[l] = '0; m_cur[l] = '1; m_loaded[l] = 0;
      end
    end else if (int_phase) begin
      int r;
      k = k + 1;
      r = k % FRAME_CLK;
      for (int l = 0; l < L; l++) begin
        if (r == R_START) m_cur[l] = m_stage[l];
        if (r == R_COMMIT) begin
          m_stage[l] = tx_load[l] ? tx_word[l*W +: W] : (m_loaded[l] ? m_hold[l] : '1);
          m_loaded[l] = 0;
        end else if (tx_load[l]) begin
          m_hold[l] = tx_word[l*W +: W];
          m_loaded[l] = 1;
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    chk(!sclk_oe, "R4 oe", int'(sclk_oe), 0);
    chk(!frame_out, "R4 frame", int'(frame_out), 0);
    if (rx_valid) begin got_cnt++; got_word = rx_word; end
  endtask

  task automatic ext_period(input logic fx, input logic fr, input logic [L-1:0] rxb,
                            output logic [L-1:0] txb);
    sclk_in = 1; fsx_n = fx; fsr_n = fr; rx_lane = rxb;
    repeat (4) tick();
    txb = tx_lane;
    sclk_in = 0;
    repeat (4) tick();
  endtask

  task automatic ext_frame(input logic use_x, input logic use_r, input logic [L*W-1:0] rxw,
                           output logic [L*W-1:0] txw);
    logic [L-1:0] b;
    got_cnt = 0;
    ext_period(!use_x, !use_r, '1, b);
    for (int p = 1; p <= W; p++) begin
      ext_period(!use_x, !use_r, {rxw[2*W-p], rxw[W-p]}, b);
      txw[2*W-p] = b[1];
      txw[W-p]   = b[0];
    end
    chk(got_cnt == 0, "R7 no early valid", got_cnt, 0);
    ext_period(1, 1, '1, b);
    ext_period(1, 1, '1, b);
  endtask

  task automatic ext_load(input logic [L-1:0] m, input logic [L*W-1:0] w);
    tx_load = m; tx_word = w;
    tick();
    tx_load = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [L*W-1:0] txw;
    repeat (3) @(negedge clk);
    chk(!sclk_oe && tx_lane == '1 && !rx_valid && !frame_out, "R1 reset",
        {sclk_oe, tx_lane, rx_valid, frame_out}, 5'b01100);
    int_phase = 1;
    rst_n = 1;
    while (k < 5 * FRAME_CLK + 50) begin
      int r, f, kn, rn, fn;
      @(negedge clk);
      r = k % FRAME_CLK; f = k / FRAME_CLK;
      if (k >= 1) begin
        chk(sclk_out == ((k / HALF) % 2 == 0), "R2 sclk", int'(sclk_out), int'((k / HALF) % 2 == 0));
        chk(sclk_oe == 1, "R2 oe", int'(sclk_oe), 1);
        chk(frame_out == ((k / DIV) % FB == 1), "R3 frame", int'(frame_out), int'((k / DIV) % FB == 1));
        for (int l = 0; l < L; l++) begin
          logic e;
          string req;
          e = (r >= R_TX0 && r < R_TX0 + W * DIV) ? m_cur[l][W-1-(r-R_TX0)/DIV] : 1'b1;
          req = (f == 4) ? "R9 tx ones" : (f == 3) ? "R10 tx bypass" : "R5 tx";
          chk(tx_lane[l] == e, req, int'(tx_lane[l]), int'(e));
        end
        chk(rx_valid == (r == R_RXV), "R6 valid", int'(rx_valid), int'(r == R_RXV));
        if (r == R_RXV)
          chk(rx_word == {pat(f, 1), pat(f, 0)}, "R6 word", int'(rx_word), int'({pat(f, 1), pat(f, 0)}));
      end
      kn = k + 1; rn = kn % FRAME_CLK; fn = kn / FRAME_CLK;
      for (int l = 0; l < L; l++)
        rx_lane[l] = (rn >= R_TX0 && rn < R_TX0 + W * DIV) ? pat(fn, l)[W-1-(rn-R_TX0)/DIV] : 1'b0;
      tx_load = '0;
      if (kn == 100) begin tx_load = 2'b01; tx_word = 16'h0096; end
      if (kn == 2 * FRAME_CLK + 5) begin tx_load = 2'b10; tx_word = 16'h1100; end
      if (kn == 2 * FRAME_CLK + R_COMMIT) begin tx_load = 2'b11; tx_word = 16'h5AC3; end
    end

    int_phase = 0;
    rst_n = 0; ext_mode = 1; tx_load = '0; rx_lane = '0;
    repeat (3) @(negedge clk);
    chk(!sclk_oe && tx_lane == '1 && !rx_valid, "R1 reset ext",
        {sclk_oe, tx_lane, rx_valid}, 4'b0110);
    rst_n = 1;
    repeat (4) tick();

    ext_load(2'b11, 16'hE73C);
    ext_frame(1, 1, 16'h7E81, txw);
    chk(txw == 16'hFFFF, "R8 not yet committed", int'(txw), 16'hFFFF);
    chk(got_cnt == 1 && got_word == 16'h7E81, "R7 rx word", int'(got_word), 16'h7E81);
    ext_frame(1, 1, 16'hA55A, txw);
    chk(txw == 16'hE73C, "R8 committed word", int'(txw), 16'hE73C);
    chk(got_cnt == 1 && got_word == 16'hA55A, "R7 rx word 2", int'(got_word), 16'hA55A);
    ext_frame(1, 1, 16'h0FF0, txw);
    chk(txw == 16'hFFFF, "R9 ext ones", int'(txw), 16'hFFFF);
    ext_load(2'b01, 16'h000F);
    ext_frame(0, 1, 16'h3355, txw);
    chk(txw == 16'hFFFF, "R11 tx idle without sync", int'(txw), 16'hFFFF);
    chk(got_cnt == 1 && got_word == 16'h3355, "R11 rx alone", int'(got_word), 16'h3355);
    ext_frame(1, 1, 16'h1234, txw);
    chk(txw == 16'hFFFF, "R11 no commit in rx-only frame", int'(txw), 16'hFFFF);
    ext_frame(1, 0, 16'h9999, txw);
    chk(txw == 16'hFF0F, "R11 pending word sent", int'(txw), 16'hFF0F);
    chk(got_cnt == 0, "R11 no rx without sync", got_cnt, 0);
    finish_run();
  end
endmodule